// File: doc/BRIEF.md
# Sequential Normalized Mantissa Divider

This block is the iterative core of a floating-point division unit. It accepts two normalized mantissas, each holding a value in [1.0, 2.0) with the leading one explicit in the top bit, together with their signed unbiased exponents. It returns a quotient mantissa that is already normalized and carries guard and round bits below its least significant position. It also returns the adjusted result exponent and a sticky bit that records whether any nonzero remainder was left. Sign logic, special operands, rounding and packing belong to the surrounding unit.

The divider is restoring and bit-serial, and it produces one quotient bit per clock. A one-cycle compare step first subtracts the divisor from the dividend. The sign of that difference decides, before any quotient bit is formed, whether the quotient needs a one-bit left normalization and an extra exponent decrement. Because of this the answer never needs a shift afterwards. Each later step shifts the partial remainder left, subtracts the divisor on trial, and keeps the difference only when its sign is non-negative.

The controller has four states. ST_IDLE waits for a start pulse and moves to ST_CMP when one arrives. ST_CMP makes the first trial and always moves to ST_ITER. ST_ITER makes one trial per cycle and stays there until its bit index reaches zero, then moves to ST_FIN. ST_FIN publishes the result and returns to ST_IDLE.

Top module: `mdiv_core`

## Requirements
- R1: A start pulse is accepted only in the idle state. It captures both mantissas and both exponents. A start pulse raised while busy is ignored, and the result then reflects the operands captured first.
- R2: When the dividend mantissa is greater than or equal to the divisor mantissa, the result exponent equals the dividend exponent minus the divisor exponent, and quotient bit MANT_W+1 (the MSB) is 1.
- R3: When the dividend mantissa is smaller than the divisor mantissa, the result exponent equals the dividend exponent minus the divisor exponent minus one, and the quotient MSB is still 1.
- R4: Read the mantissas as MANT_W-bit integers X and Y, and let Q_W = MANT_W+2. The quotient equals floor(X·2^(Q_W-1)/Y) when X ≥ Y, and floor(X·2^Q_W/Y) otherwise. The low two bits are the guard and round bits.
- R5: The sticky output is 1 exactly when the division in R4 leaves a nonzero remainder.
- R6: Done is a single-cycle pulse. Counting from the clock edge that accepts start, it appears after Q_W+1 edges when X ≥ Y, and after Q_W+2 edges otherwise.
- R7: The quotient, exponent and sticky outputs change only on the edge that raises done, and they hold their values until the next result.
- R8: Busy is high from the edge after start is accepted until done rises. Busy is low in the cycle in which done is high.
- R9: During reset, busy, done, quotient, exponent and sticky are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled when idle |
| dvd_mant_i | input | MANT_W | Dividend mantissa, top bit set |
| dvs_mant_i | input | MANT_W | Divisor mantissa, top bit set |
| dvd_exp_i | input | EXP_W | Dividend exponent, signed |
| dvs_exp_i | input | EXP_W | Divisor exponent, signed |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle result-valid pulse |
| quo_o | output | MANT_W+2 | Normalized quotient including guard and round bits |
| exp_o | output | EXP_W+2 | Signed result exponent |
| sticky_o | output | 1 | Nonzero final remainder |

## Verification
A faulty bit index or a wrong branch taken in the compare step appears at the ports first as the done pulse arriving a cycle early or late. It then appears as a quotient that is off by a power of two, or as an exponent that is off by one. A bad keep-or-replace decision in any trial corrupts the quotient from that bit position down, and it usually also flips the sticky bit. So operands whose quotients are exact and operands whose quotients repeat are both exercised, and each result is compared bit for bit the moment done rises. Output registers that leak between operations show up when the outputs are sampled several idle cycles after done, while the inputs are toggling.

// File: rtl/mdiv_pkg.sv
package mdiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMP  = 2'd1,
        ST_ITER = 2'd2,
        ST_FIN  = 2'd3
    } mdiv_state_e;

endpackage

// File: rtl/mdiv_step.sv
// One restoring trial: optional left shift of the partial remainder,
// subtract the divisor, keep the difference only if its sign is clear.
module mdiv_step #(
    parameter int W = 24
) (
    input  logic [W:0]   rem_i,
    input  logic [W-1:0] dvs_i,
    input  logic         shift_i,
    output logic         ge_o,
    output logic [W:0]   rem_o
);
    logic [W:0]   shifted;
    logic [W+1:0] trial;

    always_comb begin
        shifted = shift_i ? {rem_i[W-1:0], 1'b0} : rem_i;
        trial   = {1'b0, shifted} - {2'b00, dvs_i};
        ge_o    = ~trial[W+1];
        rem_o   = ge_o ? trial[W:0] : shifted;
    end
endmodule

// File: rtl/mdiv_ctrl.sv
module mdiv_ctrl
    import mdiv_pkg::*;
#(
    parameter int Q_W = 26,
    localparam int IDX_W = $clog2(Q_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             ge_i,
    output mdiv_state_e      state_o,
    output logic [IDX_W-1:0] idx_o
);
    mdiv_state_e state_q, state_d;
    logic        last_bit;

    assign last_bit = (idx_o == '0);
    assign state_o  = state_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_CMP;
            ST_CMP:  state_d = ST_ITER;
            ST_ITER: if (last_bit) state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
        endcase
    end

    // bit index: the compare step picks where the serial loop begins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_o <= '0;
        end else if (state_q == ST_CMP) begin
            idx_o <= ge_i ? IDX_W'(Q_W - 2) : IDX_W'(Q_W - 1);
        end else if (state_q == ST_ITER && !last_bit) begin
            idx_o <= idx_o - 1'b1;
        end
    end

    p_idx_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_ITER |-> int'(idx_o) < Q_W);

    p_busy_start_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && start_i) |=> state_q != ST_CMP);

    p_iter_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ITER && idx_o == '0) |=> state_q == ST_FIN);
endmodule

// File: rtl/mdiv_core.sv
module mdiv_core
    import mdiv_pkg::*;
#(
    parameter int MANT_W = 24,
    parameter int EXP_W  = 10,
    localparam int Q_W   = MANT_W + 2,
    localparam int EO_W  = EXP_W + 2,
    localparam int IDX_W = $clog2(Q_W)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [MANT_W-1:0]      dvd_mant_i,
    input  logic [MANT_W-1:0]      dvs_mant_i,
    input  logic signed [EXP_W-1:0] dvd_exp_i,
    input  logic signed [EXP_W-1:0] dvs_exp_i,
    output logic                   busy_o,
    output logic                   done_o,
    output logic [Q_W-1:0]         quo_o,
    output logic signed [EO_W-1:0] exp_o,
    output logic                   sticky_o
);
    mdiv_state_e             state;
    logic [IDX_W-1:0]        idx;

    logic [MANT_W-1:0]       dvd_q, dvs_q;
    logic signed [EXP_W-1:0] exa_q, exb_q;
    logic [MANT_W:0]         rem_q;
    logic [Q_W-1:0]          qacc_q;
    logic signed [EO_W-1:0]  exp_q;

    logic [MANT_W:0]         step_in, step_out;
    logic                    step_shift, step_ge;
    logic signed [EO_W-1:0]  ediff;

    // the compare step trials the unshifted dividend, later steps shift first
    assign step_in    = (state == ST_CMP) ? {1'b0, dvd_q} : rem_q;
    assign step_shift = (state != ST_CMP);
    assign ediff      = EO_W'(exa_q) - EO_W'(exb_q);
    assign busy_o     = (state != ST_IDLE);

    mdiv_ctrl #(.Q_W(Q_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .ge_i    (step_ge),
        .state_o (state),
        .idx_o   (idx)
    );

    mdiv_step #(.W(MANT_W)) u_step (
        .rem_i   (step_in),
        .dvs_i   (dvs_q),
        .shift_i (step_shift),
        .ge_o    (step_ge),
        .rem_o   (step_out)
    );

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dvd_q  <= '0;
            dvs_q  <= '0;
            exa_q  <= '0;
            exb_q  <= '0;
            rem_q  <= '0;
            qacc_q <= '0;
            exp_q  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        dvd_q <= dvd_mant_i;
                        dvs_q <= dvs_mant_i;
                        exa_q <= dvd_exp_i;
                        exb_q <= dvs_exp_i;
                    end
                end
                ST_CMP: begin
                    rem_q  <= step_out;
                    qacc_q <= step_ge ? {1'b1, {(Q_W-1){1'b0}}} : '0;
                    exp_q  <= step_ge ? ediff : ediff - EO_W'(1);
                end
                ST_ITER: begin
                    rem_q <= step_out;
                    if (step_ge) qacc_q[idx] <= 1'b1;
                end
                ST_FIN: ;
            endcase
        end
    end

    // output registers, loaded only when the result is published
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_o   <= 1'b0;
            quo_o    <= '0;
            exp_o    <= '0;
            sticky_o <= 1'b0;
        end else begin
            done_o <= (state == ST_FIN);
            if (state == ST_FIN) begin
                quo_o    <= qacc_q;
                exp_o    <= exp_q;
                sticky_o <= |rem_q;
            end
        end
    end

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_quo_normalized_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> quo_o[Q_W-1]);

    p_outputs_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(quo_o) && $stable(exp_o) && $stable(sticky_o)));

    p_idle_at_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    p_rem_below_divisor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_ITER |-> rem_q < {1'b0, dvs_q});
endmodule

// File: tb/mdiv_core_bench.sv
`timescale 1ns/1ps
module mdiv_core_bench;
    localparam int MW = 24;
    localparam int EW = 10;
    localparam int QW = MW + 2;
    localparam int OW = EW + 2;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic                 rst_n, start;
    logic [MW-1:0]        dvd, dvs;
    logic signed [EW-1:0] exa, exb;
    logic                 busy, done, sticky;
    logic [QW-1:0]        quo;
    logic signed [OW-1:0] expo;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    mdiv_core u_mdiv_core (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .dvd_mant_i(dvd), .dvs_mant_i(dvs),
        .dvd_exp_i(exa), .dvs_exp_i(exb),
        .busy_o(busy), .done_o(done), .quo_o(quo),
        .exp_o(expo), .sticky_o(sticky)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic launch(input logic [MW-1:0] x, input logic [MW-1:0] y, input int ex, input int ey);
        @(negedge clk);
        dvd = x; dvs = y; exa = EW'(ex); exb = EW'(ey); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output int lat);
        lat = 0;
        while (!done && lat < 1000) begin
            @(posedge clk); @(negedge clk);
            lat++;
        end
    endtask

    // compare the published result with a model computed from R2..R6
    task automatic check_res(input logic [MW-1:0] x, input logic [MW-1:0] y,
                             input int ex, input int ey, input int lat, input bit use_lat);
        bit ge;
        logic [63:0] num, eq, er;
        int eexp;
        ge   = (x >= y);
        num  = {40'd0, x} << (ge ? QW - 1 : QW);
        eq   = num / {40'd0, y};
        er   = num % {40'd0, y};
        eexp = ex - ey - (ge ? 0 : 1);
        chk(done === 1'b1, "R6 done seen", longint'(done), 1);
        chk(quo === eq[QW-1:0], "R4 quotient", longint'(quo), longint'(eq));
        chk(quo[QW-1] === 1'b1, ge ? "R2 msb" : "R3 msb", longint'(quo[QW-1]), 1);
        chk(int'(expo) == eexp, ge ? "R2 exponent" : "R3 exponent", longint'(int'(expo)), longint'(eexp));
        chk(sticky === (er != 0), "R5 sticky", longint'(sticky), longint'(er != 0));
        chk(busy === 1'b0, "R8 busy low at done", longint'(busy), 0);
        if (use_lat)
            chk(lat == (ge ? QW + 1 : QW + 2), "R6 latency", longint'(lat), longint'(ge ? QW + 1 : QW + 2));
    endtask

    task automatic run_op(input logic [MW-1:0] x, input logic [MW-1:0] y, input int ex, input int ey);
        int lat;
        launch(x, y, ex, ey);
        chk(busy === 1'b1, "R8 busy after start", longint'(busy), 1);
        wait_done(lat);
        check_res(x, y, ex, ey, lat, 1'b1);
        @(negedge clk);
        chk(done === 1'b0, "R6 done single cycle", longint'(done), 0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; start = 1'b0; dvd = '1; dvs = '1; exa = '1; exb = '1;
        repeat (3) @(negedge clk);
        chk(busy === 1'b0,  "R9 busy", longint'(busy), 0);
        chk(done === 1'b0,  "R9 done", longint'(done), 0);
        chk(quo === '0,     "R9 quotient", longint'(quo), 0);
        chk(expo === '0,    "R9 exponent", longint'(expo), 0);
        chk(sticky === 1'b0,"R9 sticky", longint'(sticky), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_exact;      // R2 R4 exact quotients
        run_op(24'h800000, 24'h800000, 5, 5);
        run_op(24'hC00000, 24'h800000, 10, -3);
        run_op(24'hFFFFFF, 24'h800000, 0, 0);
    endtask

    task automatic t_repeating;  // R3 R5 inexact quotients
        run_op(24'h800000, 24'hC00000, -100, 50);
        run_op(24'h800000, 24'hFFFFFF, 7, 7);
        run_op(24'hA00000, 24'hE00000, 1, -1);
    endtask

    task automatic t_exp_bounds; // R2 R3 extreme exponents
        run_op(24'h900000, 24'hF00000, -512, 511);
        run_op(24'hF00000, 24'h900000, 511, -512);
    endtask

    task automatic t_busy_start; // R1 start while busy ignored
        int lat;
        launch(24'hB00000, 24'hD00000, 3, 1);
        @(negedge clk);
        dvd = 24'hFFFFFF; dvs = 24'h800000; exa = EW'(-9); exb = EW'(9); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(lat);
        chk(lat < 1000, "R1 finished", longint'(lat), 0);
        check_res(24'hB00000, 24'hD00000, 3, 1, lat, 1'b0);
        @(negedge clk);
    endtask

    task automatic t_hold;       // R7 outputs stable between results
        logic [QW-1:0] q0;
        logic signed [OW-1:0] e0;
        logic s0;
        run_op(24'h800000, 24'hC00000, 2, 2);
        q0 = quo; e0 = expo; s0 = sticky;
        for (int i = 0; i < 6; i++) begin
            dvd = dvd ^ 24'h5A5A5A; dvs = dvs ^ 24'h3C3C3C;
            @(negedge clk);
        end
        chk(quo === q0,     "R7 quotient held", longint'(quo), longint'(q0));
        chk(expo === e0,    "R7 exponent held", longint'(expo), longint'(e0));
        chk(sticky === s0,  "R7 sticky held", longint'(sticky), longint'(s0));
        chk(done === 1'b0,  "R7 no stray done", longint'(done), 0);
    endtask

    task automatic t_sweep;      // R4 R5 mixed operands
        logic [31:0] seed;
        seed = 32'h1234_5678;
        for (int i = 0; i < 12; i++) begin
            logic [MW-1:0] x, y;
            seed = seed * 32'd1664525 + 32'd1013904223;
            x = {1'b1, seed[30:8]};
            seed = seed * 32'd1664525 + 32'd1013904223;
            y = {1'b1, seed[30:8]};
            run_op(x, y, i * 13 - 70, 40 - i * 7);
        end
    endtask

    initial begin
        t_reset();
        t_exact();
        t_repeating();
        t_exp_bounds();
        t_busy_start();
        t_hold();
        t_sweep();
        ended = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule